// File: doc/BRIEF.md
# Four-Channel PWM Host Write Port

This block is the write-only side of a four-channel pulse-width generator. A host drives an 8-bit byte, a chip select, a command/data select and a write strobe. The block watches the strobe in its own clock domain. Each low-to-high strobe transition taken while chip select is low counts as one host byte. Command bytes change per-channel configuration, the channel enables, or a byte pointer. Data bytes fill per-channel shadow copies of the prescaler, high-width and low-width values. The pointer picks where each data byte goes.

The pointer advances on its own from an upper byte to the lower byte of the same register. For a channel in the two-width mode, it also runs from the high-width lower byte into the low-width register. The byte that closes a sequence raises a one-cycle commit pulse for that channel. On the same edge, all three shadow values, including that final byte, move into the active registers that the counters use. All host pins are plain levels. Every transaction completes at once and cannot be held off, so the port has no back-pressure.

Top module: `pwm_host_if`

## Requirements
- R1: A host byte is taken on a clock edge at which `host_wr` is high, was low at the previous edge, and `cs_n` is low. A strobe edge with `cs_n` high changes no output.
- R2: With `cd` high the byte is a command. With `cd` low the byte is data and never changes configuration or enables.
- R3: A command with bit 7 set configures the channel chosen by bits 6:5. Bits 4:3 give the mode (00 single-width repeating, 01 one-shot, 10 two-width). Bit 2 selects 16-bit resolution, bit 1 the external trigger and bit 0 the high-phase polarity. These fields appear at `cfg_*` one clock after the taking edge.
- R4: A configuration command with mode bits 11 leaves every field of that channel unchanged.
- R5: A command with bits 7 and 4 both clear loads the pointer. Bits 6:5 give the channel. Bit 3 selects prescaler (0) or width register (1). Bit 2 selects low-width (0) or high-width (1) and is ignored for the prescaler. Bit 1 selects the starting byte: 0 lower, 1 upper.
- R6: A command with bit 7 clear and bit 4 set writes all four enables at once. Bit n enables channel n (channel 0 is bit 0), and a 0 disables it.
- R7: After an upper-byte start, the first data byte fills bits 15:8 and the next fills bits 7:0 of the same register.
- R8: After the high-width lower byte, a channel in mode 10 continues with the low-width upper byte and then its lower byte. Channels in any other mode complete on the high-width lower byte.
- R9: A lower-byte start is complete after that single data byte, and the upper byte keeps its previous value.
- R10: Completion raises `commit` bit of that channel for exactly one clock. The active values of that channel then show all three shadows, including the completing byte. Active values change at no other time.
- R11: Data bytes that arrive after a completed sequence, or before any pointer command, are discarded until the next pointer command.
- R12: While `rst_n` is low, every output is zero and the pointer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| cd | input | 1 | High: command byte, low: data byte |
| host_wr | input | 1 | Write strobe, sampled for its rising edge |
| host_data | input | 8 | Host byte |
| cfg_mode | output | 8 | Two mode bits per channel, channel n at bits 2n+1:2n |
| cfg_res16 | output | 4 | 16-bit resolution select per channel |
| cfg_ext_trig | output | 4 | External trigger select per channel |
| cfg_pol | output | 4 | High-phase polarity per channel |
| chan_en | output | 4 | Channel enables |
| presc_val | output | 64 | Active prescaler values, channel n at bits 16n+15:16n |
| high_val | output | 64 | Active high-width values, same packing |
| low_val | output | 64 | Active low-width values, same packing |
| commit | output | 4 | One-cycle transfer pulse per channel |

## Verification
The edge that takes a completing data byte does two things. It writes that byte into a shadow, and it copies the shadows into the active registers. A wrong merge would show up as a stale low byte in the active value. The bench closes every kind of sequence: lower-only, upper then lower, and the four-byte two-width run. It reads `commit` in the cycle after the byte, then compares all active values against a reference model built from the requirements. Random command and data streams, including prohibited modes and bytes written with chip select high, are judged the same way.

// File: rtl/pwm_host_pkg.sv
package pwm_host_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_TWO_WIDTH = 2'b10;
  localparam logic [MODE_W-1:0] MODE_BAD       = 2'b11;

  typedef enum logic [1:0] {FLD_PRE = 2'd0, FLD_HI = 2'd1, FLD_LO = 2'd2} fld_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              res16;
    logic              trig;
    logic              pol;
  } chcfg_t;
endpackage

// File: rtl/pwm_wr_edge.sv
module pwm_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic cs_n,
  input  logic cd,
  output logic cmd_v,
  output logic dat_v
);
  logic wr_q;
  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= host_wr;
  end

  assign take  = host_wr & ~wr_q & ~cs_n;
  assign cmd_v = take & cd;
  assign dat_v = take & ~cd;
endmodule

// File: rtl/pwm_byte_seq.sv
module pwm_byte_seq
  import pwm_host_pkg::*;
#(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [CHW-1:0] ld_ch,
  input  fld_e           ld_fld,
  input  logic           ld_up,
  input  logic           adv,
  input  logic           sel_two_width,
  output logic           busy,
  output logic [CHW-1:0] ch,
  output fld_e           fld,
  output logic           upper,
  output logic           last
);
  assign last = busy & ~upper & ((fld != FLD_HI) | ~sel_two_width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ch    <= '0;
      fld   <= FLD_PRE;
      upper <= 1'b0;
    end else if (ld) begin
      busy  <= 1'b1;
      ch    <= ld_ch;
      fld   <= ld_fld;
      upper <= ld_up;
    end else if (adv && busy) begin
      if (last) begin
        busy <= 1'b0;
      end else if (upper) begin
        upper <= 1'b0;
      end else begin
        fld   <= FLD_LO;
        upper <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_host_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  chcfg_t          cfg_in,
  input  logic            en_we,
  input  logic            en_in,
  input  logic            dat_we,
  input  fld_e            fld,
  input  logic            upper,
  input  logic [BW-1:0]   din,
  input  logic            fin,
  output chcfg_t          cfg,
  output logic            en,
  output logic [2*BW-1:0] pre_q,
  output logic [2*BW-1:0] hi_q,
  output logic [2*BW-1:0] lo_q,
  output logic            commit
);
  localparam int RW = 2 * BW;

  logic [RW-1:0] sh_pre, sh_hi, sh_lo;
  logic [RW-1:0] nx_pre, nx_hi, nx_lo;

  function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] old,
                                             input logic up,
                                             input logic [BW-1:0] b);
    put_byte = up ? {b, old[BW-1:0]} : {old[RW-1:BW], b};
  endfunction

  always_comb begin
    nx_pre = sh_pre;
    nx_hi  = sh_hi;
    nx_lo  = sh_lo;
    if (dat_we) begin
      case (fld)
        FLD_PRE: nx_pre = put_byte(sh_pre, upper, din);
        FLD_HI:  nx_hi  = put_byte(sh_hi, upper, din);
        default: nx_lo  = put_byte(sh_lo, upper, din);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      en     <= 1'b0;
      sh_pre <= '0;
      sh_hi  <= '0;
      sh_lo  <= '0;
      pre_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      commit <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_in;
      if (en_we)  en  <= en_in;
      sh_pre <= nx_pre;
      sh_hi  <= nx_hi;
      sh_lo  <= nx_lo;
      commit <= fin;
      if (fin) begin
        pre_q <= nx_pre;
        hi_q  <= nx_hi;
        lo_q  <= nx_lo;
      end
    end
  end
endmodule

// File: rtl/pwm_host_if.sv
module pwm_host_if
  import pwm_host_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   cd,
  input  logic                   host_wr,
  input  logic [BYTE_W-1:0]      host_data,
  output logic [NCH*MODE_W-1:0]  cfg_mode,
  output logic [NCH-1:0]         cfg_res16,
  output logic [NCH-1:0]         cfg_ext_trig,
  output logic [NCH-1:0]         cfg_pol,
  output logic [NCH-1:0]         chan_en,
  output logic [NCH*REG_W-1:0]   presc_val,
  output logic [NCH*REG_W-1:0]   high_val,
  output logic [NCH*REG_W-1:0]   low_val,
  output logic [NCH-1:0]         commit
);
  logic cmd_v, dat_v;
  logic is_cfg, is_ptr, is_en, cfg_ok;
  logic [CH_W-1:0] cmd_ch;
  fld_e cmd_fld;
  chcfg_t cfg_in;

  logic seq_busy, seq_up, seq_last, seq_two;
  logic [CH_W-1:0] seq_ch;
  fld_e seq_fld;

  chcfg_t cfg_a [NCH];
  logic [NCH-1:0] two_width;

  pwm_wr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .cs_n(cs_n), .cd(cd),
    .cmd_v(cmd_v), .dat_v(dat_v)
  );

  assign is_cfg = host_data[7];
  assign is_en  = ~host_data[7] & host_data[4];
  assign is_ptr = ~host_data[7] & ~host_data[4];
  assign cmd_ch = host_data[6:5];
  assign cfg_ok = host_data[4:3] != MODE_BAD;
  assign cfg_in = '{mode: host_data[4:3], res16: host_data[2],
                    trig: host_data[1], pol: host_data[0]};
  assign cmd_fld = host_data[3] ? (host_data[2] ? FLD_HI : FLD_LO) : FLD_PRE;

  assign seq_two = two_width[seq_ch];

  pwm_byte_seq #(.CHW(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ld(cmd_v & is_ptr), .ld_ch(cmd_ch), .ld_fld(cmd_fld), .ld_up(host_data[1]),
    .adv(dat_v), .sel_two_width(seq_two),
    .busy(seq_busy), .ch(seq_ch), .fld(seq_fld), .upper(seq_up), .last(seq_last)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = dat_v & seq_busy & (seq_ch == CH_W'(i));

    pwm_chan_regs #(.BW(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cmd_v & is_cfg & cfg_ok & (cmd_ch == CH_W'(i))),
      .cfg_in(cfg_in),
      .en_we(cmd_v & is_en), .en_in(host_data[i]),
      .dat_we(hit), .fld(seq_fld), .upper(seq_up), .din(host_data),
      .fin(hit & seq_last),
      .cfg(cfg_a[i]), .en(chan_en[i]),
      .pre_q(presc_val[i*REG_W +: REG_W]),
      .hi_q(high_val[i*REG_W +: REG_W]),
      .lo_q(low_val[i*REG_W +: REG_W]),
      .commit(commit[i])
    );

    assign two_width[i]              = cfg_a[i].mode == MODE_TWO_WIDTH;
    assign cfg_mode[i*MODE_W +: MODE_W] = cfg_a[i].mode;
    assign cfg_res16[i]              = cfg_a[i].res16;
    assign cfg_ext_trig[i]           = cfg_a[i].trig;
    assign cfg_pol[i]                = cfg_a[i].pol;
  end
endmodule

// File: rtl/pwm_host_chk.sv
module pwm_host_chk
  import pwm_host_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  cd,
  input logic                  host_wr,
  input logic [BYTE_W-1:0]     host_data,
  input logic [NCH*MODE_W-1:0] cfg_mode,
  input logic [NCH-1:0]        chan_en,
  input logic [NCH*REG_W-1:0]  presc_val,
  input logic [NCH*REG_W-1:0]  high_val,
  input logic [NCH*REG_W-1:0]  low_val,
  input logic [NCH-1:0]        commit
);
  logic wr_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= host_wr;
  end

  p_cs_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(chan_en) && $stable(cfg_mode) && $stable(presc_val)
              && $stable(high_val) && $stable(low_val)));

  p_data_keeps_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cd |=> ($stable(chan_en) && $stable(cfg_mode)));

  p_bad_mode_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cd && host_wr && !wr_prev && host_data[7] && host_data[4:3] == MODE_BAD)
    |=> $stable(cfg_mode));

  p_commit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit));

  p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit != '0) |=> (commit == '0));

  p_active_on_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((presc_val != $past(presc_val)) || (high_val != $past(high_val))
     || (low_val != $past(low_val))) |-> (commit != '0));
endmodule

bind pwm_host_if pwm_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .host_wr(host_wr),
  .host_data(host_data), .cfg_mode(cfg_mode), .chan_en(chan_en),
  .presc_val(presc_val), .high_val(high_val), .low_val(low_val), .commit(commit)
);

// File: tb/pwm_host_if_bench.sv
`timescale 1ns/1ps
module pwm_host_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic cd = 1'b0;
  logic host_wr = 1'b0;
  logic [7:0] host_data = '0;
  logic [7:0]  cfg_mode;
  logic [3:0]  cfg_res16, cfg_ext_trig, cfg_pol, chan_en, commit;
  logic [63:0] presc_val, high_val, low_val;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_host_if u_pwm_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .host_wr(host_wr),
    .host_data(host_data), .cfg_mode(cfg_mode), .cfg_res16(cfg_res16),
    .cfg_ext_trig(cfg_ext_trig), .cfg_pol(cfg_pol), .chan_en(chan_en),
    .presc_val(presc_val), .high_val(high_val), .low_val(low_val), .commit(commit)
  );

  // reference model built from the requirements
  logic [1:0]  m_mode [4];
  logic [3:0]  m_res, m_trig, m_pol, m_en;
  logic [15:0] m_pre [4], m_hi [4], m_lo [4];
  logic [15:0] s_pre [4], s_hi [4], s_lo [4];
  bit          p_busy;
  int          p_ch, p_fld, p_up;   // p_fld: 0 prescaler, 1 high, 2 low
  logic [3:0]  exp_commit;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 0; m_pre[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
      s_pre[i] = 0; s_hi[i] = 0; s_lo[i] = 0;
    end
    m_res = 0; m_trig = 0; m_pol = 0; m_en = 0;
    p_busy = 0; p_ch = 0; p_fld = 0; p_up = 0;
  endtask

  function automatic logic [15:0] put(input logic [15:0] o, input int up, input logic [7:0] b);
    return up != 0 ? {b, o[7:0]} : {o[15:8], b};
  endfunction

  task automatic model_byte(input bit c, input bit csn, input logic [7:0] d);
    exp_commit = 0;
    if (csn) return;
    if (c) begin
      if (d[7]) begin
        if (d[4:3] != 2'b11) begin
          m_mode[d[6:5]] = d[4:3];
          m_res[d[6:5]] = d[2]; m_trig[d[6:5]] = d[1]; m_pol[d[6:5]] = d[0];
        end
      end else if (d[4]) begin
        m_en = d[3:0];
      end else begin
        p_busy = 1; p_ch = int'(d[6:5]); p_up = int'(d[1]);
        p_fld = d[3] ? (d[2] ? 1 : 2) : 0;
      end
    end else if (p_busy) begin
      if (p_fld == 0)      s_pre[p_ch] = put(s_pre[p_ch], p_up, d);
      else if (p_fld == 1) s_hi[p_ch]  = put(s_hi[p_ch], p_up, d);
      else                 s_lo[p_ch]  = put(s_lo[p_ch], p_up, d);
      if (p_up == 0 && (p_fld != 1 || m_mode[p_ch] != 2'b10)) begin
        m_pre[p_ch] = s_pre[p_ch]; m_hi[p_ch] = s_hi[p_ch]; m_lo[p_ch] = s_lo[p_ch];
        exp_commit[p_ch] = 1'b1;
        p_busy = 0;
      end else if (p_up != 0) begin
        p_up = 0;
      end else begin
        p_fld = 2; p_up = 1;
      end
    end
  endtask

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] em;
    logic [63:0] ep, eh, el;
    for (int i = 0; i < 4; i++) begin
      em[2*i +: 2] = m_mode[i];
      ep[16*i +: 16] = m_pre[i]; eh[16*i +: 16] = m_hi[i]; el[16*i +: 16] = m_lo[i];
    end
    check({tag, " cfg"}, 256'({cfg_mode, cfg_res16, cfg_ext_trig, cfg_pol, chan_en}),
                         256'({em, m_res, m_trig, m_pol, m_en}));
    check({tag, " values"}, 256'({presc_val, high_val, low_val, commit}),
                            256'({ep, eh, el, 4'b0}));
  endtask

  task automatic send(input bit c, input bit csn, input logic [7:0] d, input string tag);
    model_byte(c, csn, d);
    cs_n = csn; cd = c; host_data = d; host_wr = 1'b1;
    @(negedge clk);
    check({tag, " commit"}, 256'(commit), 256'(exp_commit));
    host_wr = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R12 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    model_reset();
    @(negedge clk);
    do_reset();
    // R1: strobe with chip select high
    send(1, 1, 8'h1F, "R1 cs high ignored");
    // R6: enables
    send(1, 0, 8'h15, "R6 enable 0101");
    // R3: configure channel 2 as two-width, 16-bit, trig, pol
    send(1, 0, 8'b1_10_10_1_1_1, "R3 cfg ch2");
    // R4: prohibited mode leaves ch2 alone
    send(1, 0, 8'b1_10_11_0_0_0, "R4 mode 11 ignored");
    // R2 / R5 / R7 / R8: ch2 high upper start, four-byte run
    send(1, 0, 8'b0_10_0_1_1_1_0, "R5 ptr ch2 high upper");
    send(0, 0, 8'h12, "R7 high upper no commit");
    send(0, 0, 8'h34, "R8 high lower continues");
    send(0, 0, 8'h56, "R8 low upper");
    send(0, 0, 8'h78, "R10 low lower commits");
    // R11: extra data discarded
    send(0, 0, 8'h99, "R11 extra byte dropped");
    // R9: prescaler lower-only on ch0
    send(1, 0, 8'b0_00_0_0_0_0_0, "R5 ptr ch0 pre lower");
    send(0, 0, 8'hAB, "R9 lower-only commit");
    // R7: prescaler upper start on ch1
    send(1, 0, 8'b0_01_0_0_1_1_0, "R5 ptr ch1 pre upper");
    send(0, 0, 8'hC3, "R7 pre upper");
    send(0, 0, 8'h3C, "R7 pre lower commit");
    // R8: mode 0 channel finishes at high lower
    send(1, 0, 8'b1_11_00_0_0_1, "R3 cfg ch3 mode0");
    send(1, 0, 8'b0_11_0_1_1_1_0, "R5 ptr ch3 high upper");
    send(0, 0, 8'hDE, "R7 ch3 high upper");
    send(0, 0, 8'hAD, "R8 ch3 completes at high lower");
    send(0, 0, 8'h11, "R11 ch3 after completion");
    // R12: reset mid-sequence clears everything and the pointer
    send(1, 0, 8'b0_01_0_1_0_1_0, "R5 ptr ch1 low upper");
    send(0, 0, 8'h44, "R7 ch1 low upper");
    do_reset();
    send(0, 0, 8'h55, "R12 R11 pointer cleared");
    // random stream
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [7:0] rb;
      r  = int'($urandom % 10);
      rb = 8'($urandom);
      case (r)
        0:       send(1'($urandom), 1, rb, "R1 random cs high");
        1, 2:    send(1, 0, {1'b1, rb[6:0]}, "R3 R4 random cfg");
        3:       send(1, 0, {1'b0, rb[6:5], 1'b1, rb[3:0]}, "R6 random enable");
        4, 5:    send(1, 0, {1'b0, rb[6:5], 1'b0, rb[3:0]}, "R5 random pointer");
        default: send(0, 0, rb, "R2 R10 random data");
      endcase
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule